// File: doc/BRIEF.md
# DRAM Bank Issue Scheduler

This block sits between the request side of a memory controller and the command generator for one DRAM channel. Each incoming request carries an address and a read/write flag. The address is decoded into a global bank index, and the request waits in a small input FIFO. From there it moves into a per-bank queue. Every memory cycle the scheduler scans the banks in rotating order and issues at most one command. That command is either the head request of a bank queue or a refresh. The policy is closed-bank: the activate and the column access go out together, and the bank closes again by itself. So each issue occupies its bank for a fixed number of cycles.

Shared resources are tracked with three bus counters. The first is a basic occupancy counter that spaces every command. The second blocks writes. The third blocks reads that switch to a different rank. After a read, the write counter and the rank-switch counter are reloaded with longer values than after a write or a refresh. This inserts the read-to-write turnaround bubble and the rank-to-rank bubble. Refresh demand builds up at a fixed rate. It is served one bank at a time in rotating bank order, through the same bank and bus checks as ordinary requests.

Top module: `dram_bank_sched`

## Requirements
- R1: The global bank index is {dimm, rank, bank}, taken as fields of `in_addr`. The bank field starts at bit BANK_LSB and is log2(BANKS_PER_RANK) bits wide. The rank field starts at bit RANK_LSB and is log2(RANKS_PER_DIMM) bits wide. The dimm field starts at bit DIMM_LSB and is log2(DIMMS) bits wide. The rank of a bank is its index divided by BANKS_PER_RANK.
- R2: The block issues at most one command per cycle. `iss_valid` is high for exactly that cycle, together with `iss_bank`, `iss_write` (1 = write, 0 = read) and `iss_refresh`. A refresh issue always shows `iss_write` = 0.
- R3: After any issue to a bank in cycle t, that bank issues nothing before cycle t+BANK_BUSY.
- R4: After any issue in cycle t, nothing issues before cycle t+BUS_BUSY.
- R5: A write issues no earlier than BUS_BUSY+RW_DELAY cycles after a read. After a write or a refresh, the spacing is only BUS_BUSY cycles.
- R6: A read to a rank other than the rank of the last issued request waits BUS_BUSY+RR_DELAY cycles after a read, and BUS_BUSY cycles after a write or a refresh. A read to the same rank needs only the basic spacing.
- R7: A pending-refresh count rises by one every REFRESH_PERIOD/total_banks cycles. It first rises after that many cycles from reset and saturates at PEND_MAX. A refresh issues only at the refresh pointer bank, which starts at bank 0 and advances by one, modulo the total bank count, on each refresh. Each refresh lowers the pending count by one.
- R8: The scan starts at the bank after the last issued bank (bank 0 first after reset). At each bank a due refresh is considered before that bank's head request. The first eligible candidate issues.
- R9: `in_ready` is high while the input FIFO holds fewer than IN_DEPTH entries. Each cycle, at most one entry moves from the input FIFO head to its bank queue, and only if that queue holds fewer than QUEUE_DEPTH entries at the start of the cycle. A blocked head stalls all entries behind it. Each bank issues its requests in arrival order.
- R10: A request accepted in cycle t can issue no earlier than cycle t+2.
- R11: After reset no command issues, `in_ready` is high, and all bank and bus counters are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory cycle clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | New request offered |
| in_write | input | 1 | Request is a write (1) or read (0) |
| in_addr | input | ADDR_W | Request address used for bank decode |
| in_ready | output | 1 | Input FIFO can take a request this cycle |
| iss_valid | output | 1 | Command issued this cycle |
| iss_write | output | 1 | Issued request is a write |
| iss_refresh | output | 1 | Issued command is a refresh |
| iss_bank | output | log2(total banks) | Global bank index of the issued command |

## Verification
The bench uses the defaults: 4 banks per rank, 2 ranks per DIMM and 2 DIMMs, which gives 16 banks over 4 ranks. It also uses a 6-cycle bank busy time, a 2-cycle bus time, one-cycle turnaround and rank-switch bubbles, two-entry bank queues and a four-entry input FIFO. A refresh comes due every 40 cycles. The short refresh interval means refreshes collide with queued requests many times within a few thousand cycles. The shallow queues let a phase aimed at four hot banks fill them, so a blocked FIFO head and a falling `in_ready` can both be observed. Because there are several ranks, read-to-read rank switches and read-to-write turnarounds occur often under random traffic.

// File: rtl/dbs_pkg.sv
package dbs_pkg;
   typedef enum logic [1:0] {
      CMD_NONE    = 2'd0,
      CMD_READ    = 2'd1,
      CMD_WRITE   = 2'd2,
      CMD_REFRESH = 2'd3
   } dbs_cmd_e;

   function automatic bit is_pow2(input int v);
      return (v >= 2) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/dbs_fifo.sv
module dbs_fifo #(
   parameter int W     = 1,
   parameter int DEPTH = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         empty,
   output logic         full
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);
   localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("dbs_fifo: DEPTH must be at least 1");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wr_ptr, rd_ptr;
   logic [CW-1:0] cnt;
   logic          do_push, do_pop;

   assign empty   = (cnt == '0);
   assign full    = (cnt == CW'(DEPTH));
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (do_push) begin
            mem[wr_ptr] <= din;
            wr_ptr      <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
         end
         if (do_pop)
            rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
         if (do_push && !do_pop)
            cnt <= cnt + 1'b1;
         else if (do_pop && !do_push)
            cnt <= cnt - 1'b1;
      end
   end

   p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);
   p_no_underflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);
endmodule

// File: rtl/dbs_timers.sv
module dbs_timers
   import dbs_pkg::*;
#(
   parameter int NB        = 16,
   parameter int BPR_W     = 2,
   parameter int BANK_BUSY = 6,
   parameter int BUS_BUSY  = 2,
   parameter int RW_DELAY  = 1,
   parameter int RR_DELAY  = 1,
   localparam int BW       = $clog2(NB),
   localparam int RANK_W   = BW - BPR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  dbs_cmd_e          cmd,
   input  logic [BW-1:0]     cmd_bank,
   output logic [NB-1:0]     bank_free,
   output logic              bus_free,
   output logic              wr_free,
   output logic              nr_free,
   output logic [RANK_W-1:0] last_rank
);
   localparam int MAXD   = (RW_DELAY > RR_DELAY) ? RW_DELAY : RR_DELAY;
   localparam int BUS_CW = $clog2(BUS_BUSY + MAXD + 1);
   localparam int BNK_CW = $clog2(BANK_BUSY + 1);
   localparam logic [BUS_CW-1:0] L_BASIC = BUS_CW'(BUS_BUSY - 1);
   localparam logic [BUS_CW-1:0] L_WR_RD = BUS_CW'(BUS_BUSY + RW_DELAY - 1);
   localparam logic [BUS_CW-1:0] L_NR_RD = BUS_CW'(BUS_BUSY + RR_DELAY - 1);
   localparam logic [BNK_CW-1:0] L_BANK  = BNK_CW'(BANK_BUSY - 1);

   generate
      if (BANK_BUSY < 1 || BUS_BUSY < 1) begin : g_bad_busy
         $error("dbs_timers: busy times must be at least 1");
      end
      if (RW_DELAY < 0 || RR_DELAY < 0) begin : g_bad_delay
         $error("dbs_timers: bubble delays must not be negative");
      end
   endgenerate

   logic [BUS_CW-1:0] bas_cnt, wr_cnt, nr_cnt;
   logic              issuing;

   assign issuing  = (cmd != CMD_NONE);
   assign bus_free = (bas_cnt == '0);
   assign wr_free  = (wr_cnt == '0);
   assign nr_free  = (nr_cnt == '0);

   genvar k;
   generate
      for (k = 0; k < NB; k++) begin : g_bank
         logic [BNK_CW-1:0] cnt;
         always_ff @(posedge clk) begin
            if (!rst_n)
               cnt <= '0;
            else if (issuing && cmd_bank == BW'(k))
               cnt <= L_BANK;
            else if (cnt != '0)
               cnt <= cnt - 1'b1;
         end
         assign bank_free[k] = (cnt == '0);

         p_bank_rest_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (issuing && cmd_bank == BW'(k)) |=> !bank_free[k] || (BANK_BUSY == 1));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bas_cnt   <= '0;
         wr_cnt    <= '0;
         nr_cnt    <= '0;
         last_rank <= '0;
      end else if (issuing) begin
         bas_cnt <= L_BASIC;
         if (cmd == CMD_READ) begin
            wr_cnt <= L_WR_RD;
            nr_cnt <= L_NR_RD;
         end else begin
            wr_cnt <= L_BASIC;
            nr_cnt <= L_BASIC;
         end
         if (cmd != CMD_REFRESH)
            last_rank <= cmd_bank[BW-1:BPR_W];
      end else begin
         if (bas_cnt != '0) bas_cnt <= bas_cnt - 1'b1;
         if (wr_cnt  != '0) wr_cnt  <= wr_cnt  - 1'b1;
         if (nr_cnt  != '0) nr_cnt  <= nr_cnt  - 1'b1;
      end
   end

   p_write_turn_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_WRITE) |-> wr_free);
   p_rank_switch_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_READ && cmd_bank[BW-1:BPR_W] != last_rank) |-> nr_free);
endmodule

// File: rtl/dbs_refresh.sv
module dbs_refresh #(
   parameter int NB       = 16,
   parameter int INTERVAL = 40,
   parameter int PEND_MAX = 7,
   localparam int BW      = $clog2(NB)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ref_done,
   output logic          ref_want,
   output logic [BW-1:0] ref_bank
);
   localparam int TW = $clog2(INTERVAL + 1);
   localparam int PW = $clog2(PEND_MAX + 1);

   generate
      if (INTERVAL < 1 || PEND_MAX < 1) begin : g_bad_refresh
         $error("dbs_refresh: interval and pending limit must be at least 1");
      end
   endgenerate

   logic [TW-1:0] tmr;
   logic [PW-1:0] pend;
   logic          tick;

   assign tick     = (tmr == TW'(INTERVAL - 1));
   assign ref_want = (pend != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tmr      <= '0;
         pend     <= '0;
         ref_bank <= '0;
      end else begin
         tmr <= tick ? '0 : tmr + 1'b1;
         if (tick && !ref_done) begin
            if (pend != PW'(PEND_MAX)) pend <= pend + 1'b1;
         end else if (!tick && ref_done) begin
            pend <= pend - 1'b1;
         end
         if (ref_done)
            ref_bank <= (ref_bank == BW'(NB - 1)) ? '0 : ref_bank + 1'b1;
      end
   end

   p_pend_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      pend <= PW'(PEND_MAX));
   p_ref_needs_pend_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ref_done |-> ref_want);
   p_ref_ptr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ref_done |=> ref_bank == (($past(ref_bank) == BW'(NB - 1)) ? '0 : $past(ref_bank) + 1'b1));
endmodule

// File: rtl/dram_bank_sched.sv
module dram_bank_sched
   import dbs_pkg::*;
#(
   parameter int ADDR_W         = 16,
   parameter int BANKS_PER_RANK = 4,
   parameter int RANKS_PER_DIMM = 2,
   parameter int DIMMS          = 2,
   parameter int BANK_LSB       = 6,
   parameter int RANK_LSB       = 8,
   parameter int DIMM_LSB       = 9,
   parameter int QUEUE_DEPTH    = 2,
   parameter int IN_DEPTH       = 4,
   parameter int BANK_BUSY      = 6,
   parameter int BUS_BUSY       = 2,
   parameter int RW_DELAY       = 1,
   parameter int RR_DELAY       = 1,
   parameter int REFRESH_PERIOD = 640,
   parameter int PEND_MAX       = 7,
   localparam int BPR_W    = $clog2(BANKS_PER_RANK),
   localparam int RPD_W    = $clog2(RANKS_PER_DIMM),
   localparam int DIMM_W   = $clog2(DIMMS),
   localparam int NB       = BANKS_PER_RANK * RANKS_PER_DIMM * DIMMS,
   localparam int BW       = BPR_W + RPD_W + DIMM_W,
   localparam int RANK_W   = BW - BPR_W,
   localparam int INTERVAL = REFRESH_PERIOD / NB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_write,
   input  logic [ADDR_W-1:0] in_addr,
   output logic              in_ready,
   output logic              iss_valid,
   output logic              iss_write,
   output logic              iss_refresh,
   output logic [BW-1:0]     iss_bank
);
   generate
      if (!is_pow2(BANKS_PER_RANK) || !is_pow2(RANKS_PER_DIMM) || !is_pow2(DIMMS)) begin : g_bad_geom
         $error("dram_bank_sched: bank, rank and dimm counts must be powers of two, at least 2");
      end
      if (BANK_LSB + BPR_W > ADDR_W || RANK_LSB + RPD_W > ADDR_W || DIMM_LSB + DIMM_W > ADDR_W) begin : g_bad_field
         $error("dram_bank_sched: an address field lies outside the address");
      end
      if (INTERVAL < 1) begin : g_bad_period
         $error("dram_bank_sched: refresh period shorter than the bank count");
      end
   endgenerate

   // ---------------- decode and input FIFO ----------------
   logic [BW-1:0] dec_bank, hd_bank;
   logic          in_empty, in_full, hd_write, move;
   logic [NB-1:0] q_empty, q_full, q_head, q_pop;

   assign dec_bank = {in_addr[DIMM_LSB +: DIMM_W], in_addr[RANK_LSB +: RPD_W], in_addr[BANK_LSB +: BPR_W]};
   assign in_ready = !in_full;
   assign move     = !in_empty && !q_full[hd_bank];

   dbs_fifo #(.W(BW + 1), .DEPTH(IN_DEPTH)) u_in_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (in_valid && in_ready),
      .din   ({in_write, dec_bank}),
      .pop   (move),
      .dout  ({hd_write, hd_bank}),
      .empty (in_empty),
      .full  (in_full)
   );

   // ---------------- per-bank queues ----------------
   genvar k;
   generate
      for (k = 0; k < NB; k++) begin : g_q
         dbs_fifo #(.W(1), .DEPTH(QUEUE_DEPTH)) u_bq (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (move && hd_bank == BW'(k)),
            .din   (hd_write),
            .pop   (q_pop[k]),
            .dout  (q_head[k]),
            .empty (q_empty[k]),
            .full  (q_full[k])
         );
      end
   endgenerate

   // ---------------- timers and refresh ----------------
   dbs_cmd_e          pick_cmd;
   logic [BW-1:0]     pick_bank, rr_ptr, ref_bank, scan_b;
   logic [NB-1:0]     bank_free;
   logic              bus_free, wr_free, nr_free, ref_want;
   logic [RANK_W-1:0] last_rank;

   dbs_timers #(
      .NB(NB), .BPR_W(BPR_W), .BANK_BUSY(BANK_BUSY), .BUS_BUSY(BUS_BUSY),
      .RW_DELAY(RW_DELAY), .RR_DELAY(RR_DELAY)
   ) u_timers (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd       (pick_cmd),
      .cmd_bank  (pick_bank),
      .bank_free (bank_free),
      .bus_free  (bus_free),
      .wr_free   (wr_free),
      .nr_free   (nr_free),
      .last_rank (last_rank)
   );

   dbs_refresh #(.NB(NB), .INTERVAL(INTERVAL), .PEND_MAX(PEND_MAX)) u_refresh (
      .clk      (clk),
      .rst_n    (rst_n),
      .ref_done (pick_cmd == CMD_REFRESH),
      .ref_want (ref_want),
      .ref_bank (ref_bank)
   );

   // ---------------- rotating scan ----------------
   always_comb begin
      pick_cmd  = CMD_NONE;
      pick_bank = '0;
      scan_b    = '0;
      if (bus_free) begin
         for (int i = 1; i <= NB; i++) begin
            scan_b = rr_ptr + BW'(i);
            if (pick_cmd == CMD_NONE && bank_free[scan_b]) begin
               if (ref_want && ref_bank == scan_b) begin
                  pick_cmd  = CMD_REFRESH;
                  pick_bank = scan_b;
               end else if (!q_empty[scan_b]) begin
                  if (q_head[scan_b] ? wr_free
                                     : (scan_b[BW-1:BPR_W] == last_rank || nr_free)) begin
                     pick_cmd  = q_head[scan_b] ? CMD_WRITE : CMD_READ;
                     pick_bank = scan_b;
                  end
               end
            end
         end
      end
   end

   always_comb begin
      q_pop = '0;
      if (pick_cmd == CMD_READ || pick_cmd == CMD_WRITE)
         q_pop[pick_bank] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         rr_ptr <= BW'(NB - 1);
      else if (pick_cmd != CMD_NONE)
         rr_ptr <= pick_bank;
   end

   assign iss_valid   = (pick_cmd != CMD_NONE);
   assign iss_write   = (pick_cmd == CMD_WRITE);
   assign iss_refresh = (pick_cmd == CMD_REFRESH);
   assign iss_bank    = pick_bank;

   // ---------------- checks ----------------
   localparam int GW = $clog2(BUS_BUSY + 1);
   logic [GW-1:0] gap;
   always_ff @(posedge clk) begin
      if (!rst_n)
         gap <= GW'(BUS_BUSY);
      else if (iss_valid)
         gap <= GW'(1);
      else if (gap < GW'(BUS_BUSY))
         gap <= gap + 1'b1;
   end

   p_bus_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid |-> gap >= GW'(BUS_BUSY));
   p_refresh_flags_r2: assert property (@(posedge clk) disable iff (!rst_n)
      iss_refresh |-> iss_valid && !iss_write);
   p_issue_has_head_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid && !iss_refresh) |-> !q_empty[iss_bank]);
   p_reset_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !iss_valid);
endmodule

// File: tb/dram_bank_sched_bench.sv
`timescale 1ns/1ps
module dram_bank_sched_bench;
   localparam int ADDR_W = 16, BPR = 4, RPD = 2, DIMMS = 2;
   localparam int BANK_LSB = 6, RANK_LSB = 8, DIMM_LSB = 9;
   localparam int QD = 2, IND = 4, BANK_BUSY = 6, BUS_BUSY = 2;
   localparam int RW_DELAY = 1, RR_DELAY = 1, REFRESH_PERIOD = 640, PEND_MAX = 7;
   localparam int NB = BPR * RPD * DIMMS;
   localparam int BW = $clog2(NB);
   localparam int INTERVAL = REFRESH_PERIOD / NB;
   localparam int NCYC = 4500;

   logic clk = 1'b0, rst_n = 1'b0;
   logic in_valid = 1'b0, in_write = 1'b0;
   logic [ADDR_W-1:0] in_addr = '0;
   logic in_ready, iss_valid, iss_write, iss_refresh;
   logic [BW-1:0] iss_bank;

   always #2 clk = ~clk;

   dram_bank_sched u_dram_bank_sched (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_write(in_write),
      .in_addr(in_addr), .in_ready(in_ready), .iss_valid(iss_valid),
      .iss_write(iss_write), .iss_refresh(iss_refresh), .iss_bank(iss_bank)
   );

   int n_checks = 0, n_fail = 0;
   bit finished = 0;

   // expected-value state
   int  iqb [IND];
   bit  iqw [IND];
   int  iqn;
   bit  bqd [NB][QD];
   int  bqn [NB];
   int  m_bank [NB];
   int  m_bas, m_wr, m_nr, m_last, m_rr, m_tmr, m_pend, m_rptr;
   bit  e_f, e_r, e_w;
   int  e_b;

   function automatic int decode(input logic [ADDR_W-1:0] a);
      return ((int'(a >> DIMM_LSB) & (DIMMS - 1)) * RPD * BPR)
           + ((int'(a >> RANK_LSB) & (RPD - 1)) * BPR)
           +  (int'(a >> BANK_LSB) & (BPR - 1));
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      iqn = 0; m_bas = 0; m_wr = 0; m_nr = 0; m_last = 0;
      m_rr = NB - 1; m_tmr = 0; m_pend = 0; m_rptr = 0;
      for (int b = 0; b < NB; b++) begin bqn[b] = 0; m_bank[b] = 0; end
   endtask

   task automatic model_pick();
      e_f = 0; e_r = 0; e_w = 0; e_b = 0;
      if (m_bas == 0)
         for (int i = 1; i <= NB; i++) begin
            int c = (m_rr + i) % NB;
            if (!e_f && m_bank[c] == 0) begin
               if (m_pend > 0 && m_rptr == c) begin
                  e_f = 1; e_r = 1; e_b = c;
               end else if (bqn[c] > 0 &&
                            (bqd[c][0] ? (m_wr == 0) : ((c / BPR) == m_last || m_nr == 0))) begin
                  e_f = 1; e_w = bqd[c][0]; e_b = c;
               end
            end
         end
   endtask

   task automatic model_step();
      bit mv, acc, tick;
      mv  = (iqn > 0) && (bqn[iqb[0]] < QD);
      acc = in_valid && (iqn < IND);
      for (int b = 0; b < NB; b++)
         m_bank[b] = (e_f && e_b == b) ? BANK_BUSY - 1 : (m_bank[b] > 0 ? m_bank[b] - 1 : 0);
      if (e_f) begin
         m_bas = BUS_BUSY - 1;
         m_wr  = (!e_r && !e_w) ? BUS_BUSY + RW_DELAY - 1 : BUS_BUSY - 1;
         m_nr  = (!e_r && !e_w) ? BUS_BUSY + RR_DELAY - 1 : BUS_BUSY - 1;
         m_rr  = e_b;
         if (!e_r) begin
            m_last = e_b / BPR;
            for (int j = 0; j < QD - 1; j++) bqd[e_b][j] = bqd[e_b][j+1];
            bqn[e_b]--;
         end else begin
            m_rptr = (m_rptr + 1) % NB;
         end
      end else begin
         if (m_bas > 0) m_bas--;
         if (m_wr > 0) m_wr--;
         if (m_nr > 0) m_nr--;
      end
      tick  = (m_tmr == INTERVAL - 1);
      m_tmr = tick ? 0 : m_tmr + 1;
      if (tick && !(e_f && e_r)) begin
         if (m_pend < PEND_MAX) m_pend++;
      end else if (!tick && e_f && e_r) m_pend--;
      if (mv) begin
         bqd[iqb[0]][bqn[iqb[0]]] = iqw[0];
         bqn[iqb[0]]++;
         for (int j = 0; j < IND - 1; j++) begin iqb[j] = iqb[j+1]; iqw[j] = iqw[j+1]; end
         iqn--;
      end
      if (acc) begin
         iqb[iqn] = decode(in_addr);
         iqw[iqn] = in_write;
         iqn++;
      end
   endtask

   task automatic drive(input int cyc);
      logic [ADDR_W-1:0] a;
      int pct;
      if (cyc == 0) begin
         in_valid = 1; in_write = 1;
         in_addr  = ADDR_W'((1 << DIMM_LSB) | (2 << BANK_LSB));
         return;
      end
      if (cyc < 10) begin in_valid = 0; return; end
      pct = (cyc < 1500) ? 40 : (cyc < 3000) ? 95 : 60;
      in_valid = ($urandom_range(0, 99) < pct);
      in_write = $urandom_range(0, 2) == 0;
      a = ADDR_W'($urandom);
      if (cyc >= 1500 && cyc < 3000) begin
         a[DIMM_LSB] = 1'b0;
         a[BANK_LSB +: 2] = 2'($urandom_range(0, 1));
      end
      in_addr = a;
   endtask

   initial begin
      void'($urandom(32'd4242));
      model_reset();
      repeat (5) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      #0.5;
      check(in_ready === 1'b1, "R11 in_ready after reset", int'(in_ready), 1);
      check(iss_valid === 1'b0, "R11 no issue after reset", int'(iss_valid), 0);
      for (int cyc = 0; cyc < NCYC; cyc++) begin
         if (cyc > 0) @(negedge clk);
         model_pick();
         check(iss_valid === e_f, "R3,R4,R5,R6,R8 issue timing", int'(iss_valid), int'(e_f));
         check(in_ready === (iqn < IND), "R9 input ready", int'(in_ready), int'(iqn < IND));
         if (e_f && iss_valid === 1'b1) begin
            check(int'(iss_bank) == e_b, "R1,R8 issued bank", int'(iss_bank), e_b);
            check(iss_refresh === e_r, "R7 refresh flag", int'(iss_refresh), int'(e_r));
            check(iss_write === e_w, "R9 issue order / write flag", int'(iss_write), int'(e_w));
         end
         if (iss_refresh === 1'b1)
            check(iss_write === 1'b0 && iss_valid === 1'b1, "R2 refresh shows no write", int'(iss_write), 0);
         if (cyc == 1)
            check(iss_valid === 1'b0, "R10 no issue one cycle after accept", int'(iss_valid), 0);
         if (cyc == 2) begin
            check(iss_valid === 1'b1, "R10 issue two cycles after accept", int'(iss_valid), 1);
            check(iss_bank === BW'(10), "R1 decode dimm1 rank0 bank2", int'(iss_bank), 10);
            check(iss_write === 1'b1, "R2 write flag", int'(iss_write), 1);
         end
         drive(cyc);
         model_step();
      end
      in_valid = 0;
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end
endmodule